// File: doc/BRIEF.md
# SPI Serial Flash Command Front-End

This block is the slave-side serial engine of a small SPI NOR flash model. It oversamples chip select, SCK, SI and a hold input on the system clock. It decodes the opcode that follows each chip-select fall, collects a 24-bit address and an optional dummy byte, and then acts on the command. It can stream array bytes from a synchronous read port, stream the status byte supplied by a neighbouring status/protection block, or stream identification bytes. Write-type commands are turned into one-cycle requests to that neighbour, and the array itself sits behind a plain RAM port.

Program data is collected in a page buffer as it arrives. Write-type commands take effect only when chip select rises on a byte boundary, so a command that is cut short leaves no trace. After a valid program command, the buffered bytes are issued as a burst of per-byte requests. A busy flag from the neighbour blocks every command except the status read. The serial clock must stay at least six system clocks in each phase, so that one memory read fits between an input bit and the output bit that depends on it.

Top module: `spi_flash_frontend`

## Requirements
- R1: After reset, so_oe, req_valid and mem_rd_en are all 0.
- R2: Opcode 03h is followed by 3 address bytes, sent MSB first. Address bits above ADDR_W are ignored. SI is sampled on the rising edge of SCK. From the falling edge after the last address bit, SO shifts out, MSB first, the bytes at consecutive addresses, with so_oe at 1.
- R3: SPI mode 3 (SCK high while idle and at chip-select fall) produces the same bytes as mode 0.
- R4: Opcode 0Bh takes 3 address bytes and then one ignored dummy byte before the data stream starts.
- R5: The read address wraps from the top address (2^ADDR_W − 1) to 0.
- R6: Opcode 05h repeats the status_byte input without limit. The value is sampled at the start of each output byte.
- R7: Opcode 9Fh streams the three ID bytes (0x5A, 0x3C, 0x12) cyclically. Opcode ABh followed by three bytes streams DEV_ID (0x47) repeatedly. ABh followed directly by deselect issues request kind 9 (release).
- R8: Hold starts when hold_n falls while SCK is low, and ends when hold_n rises while SCK is low. During hold, so_oe is 0 and SCK edges are ignored. A chip-select rise during hold returns the block to standby.
- R9: On a chip-select rise at a byte boundary, these commands issue exactly one req_valid pulse with the listed req_kind: 06h gives 1, 04h gives 2, 60h and C7h give 5, B9h gives 8. Opcode 01h plus one data byte gives kind 7, with req_data set to that byte.
- R10: Opcodes 20h and D7h plus 3 address bytes give kind 3, with the address's low 12 bits cleared. Opcode D8h gives kind 4, with the low 16 bits cleared.
- R11: Opcode 02h plus an address and 1 or more data bytes gives, after deselect, one kind-6 request per page offset written. The offset wraps within the 256-byte page, and when more than 256 bytes arrive, the last byte written to each offset is the one kept.
- R12: A chip-select rise in the middle of a byte, or before a command's bytes are complete, issues no request. The next command then works normally.
- R13: While busy is 1 at opcode completion, only 05h runs. Any other opcode gives no output and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | SO output enable (0 = high impedance) |
| busy | input | 1 | Internal write in progress |
| status_byte | input | 8 | Status value to stream for 05h |
| mem_rd_en | output | 1 | Array read strobe |
| mem_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array data, one cycle after the strobe |
| req_valid | output | 1 | One-cycle request pulse |
| req_kind | output | 4 | Request code (see R7, R9 to R11) |
| req_addr | output | ADDR_W | Request address |
| req_data | output | 8 | Request data byte |

## Verification
Reads are driven in mode 0 and mode 3, at a low address whose upper address byte carries don't-care bits, and across the top address. This separates correct bit order, correct clock-edge choice, address truncation and wrap. Fast read is compared with normal read at the same address, which shows whether the dummy byte is skipped. The program pattern starts near the end of a page and then overruns a whole page, which separates in-page wrap from linear increment and shows which byte survives at each offset. Aborts mid-byte and mid-address, hold in the middle of an output byte, and commands issued while busy show that nothing leaks out of an incomplete or blocked command.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [3:0] {
    K_NONE = 4'd0, K_WREN = 4'd1, K_WRDI = 4'd2, K_SECT = 4'd3, K_BLK = 4'd4,
    K_CHIP = 4'd5, K_PROG = 4'd6, K_WRSR = 4'd7, K_DPD  = 4'd8, K_RDPD = 4'd9
  } req_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_OPC, S_ADDR, S_DUMMY, S_WSR, S_PROG, S_ARMED,
    S_RD, S_STAT, S_JID, S_RID, S_SKIP, S_DRAIN
  } eng_state_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SE_A  = 8'h20;
  localparam logic [7:0] OP_SE_B  = 8'hD7;
  localparam logic [7:0] OP_BE    = 8'hD8;
  localparam logic [7:0] OP_CE_A  = 8'h60;
  localparam logic [7:0] OP_CE_B  = 8'hC7;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_JID   = 8'h9F;
  localparam logic [7:0] OP_DPD   = 8'hB9;
  localparam logic [7:0] OP_RID   = 8'hAB;
endpackage

// File: rtl/sfe_pin_front.sv
module sfe_pin_front (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_n_i,
  output logic sel_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o,
  output logic held_o
);
  logic cs_q, cs_p, sck_q, sck_p, hold_q, hold_p, si_q, held;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1; cs_p <= 1'b1; sck_q <= 1'b0; sck_p <= 1'b0;
      hold_q <= 1'b1; hold_p <= 1'b1; si_q <= 1'b0;
    end else begin
      cs_q <= cs_n_i; cs_p <= cs_q;
      sck_q <= sck_i; sck_p <= sck_q;
      hold_q <= hold_n_i; hold_p <= hold_q;
      si_q <= si_i;
    end
  end

  // Pause state: entered and left only while SCK is low.
  always_ff @(posedge clk) begin
    if (rst || cs_q) held <= 1'b0;
    else if (!held && !hold_q && hold_p && !sck_q) held <= 1'b1;
    else if (held && hold_q && !sck_q) held <= 1'b0;
  end

  assign sel_o      = !cs_q;
  assign cs_fall_o  = !cs_q && cs_p;
  assign cs_rise_o  = cs_q && !cs_p;
  assign sck_rise_o = sck_q && !sck_p && !cs_q && !held;
  assign sck_fall_o = !sck_q && sck_p && !cs_q && !held;
  assign si_o       = si_q;
  assign held_o     = held;

  // R8
  hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> !$past(sck_q));
endmodule

// File: rtl/sfe_page_buf.sv
module sfe_page_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/sfe_cmd_engine.sv
module sfe_cmd_engine
  import sfe_pkg::*;
#(
  parameter int          ADDR_W     = 18,
  parameter int          PAGE_BYTES = 256,
  parameter int          SEC_BITS   = 12,
  parameter int          BLK_BITS   = 16,
  parameter logic [23:0] JEDEC_ID   = 24'h5A3C12,
  parameter logic [7:0]  DEV_ID     = 8'h47,
  localparam int         PW         = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si,
  input  logic              held,
  input  logic              busy,
  input  logic [7:0]        status,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              so,
  output logic              so_oe,
  output logic              req_valid,
  output logic [3:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic              pb_we,
  output logic [PW-1:0]     pb_waddr,
  output logic [7:0]        pb_wdata,
  output logic [PW-1:0]     pb_raddr,
  input  logic [7:0]        pb_rdata
);
  localparam logic [ADDR_W-1:0] SEC_MASK = {ADDR_W{1'b1}} << SEC_BITS;
  localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << BLK_BITS;
  localparam logic [ADDR_W-1:0] ONE_A    = 1;
  localparam logic [PW:0]       ONE_C    = 1;
  localparam logic [PW-1:0]     ONE_P    = 1;
  localparam logic [PW:0]       PAGE_CNT = (PW+1)'(PAGE_BYTES);

  eng_state_e        state;
  req_kind_e         pend_kind;
  logic [2:0]        bit_cnt, obit;
  logic [6:0]        sh, osh;
  logic [7:0]        opc, mem_q, pend_data, ld;
  logic [1:0]        addr_cnt, id_idx;
  logic [ADDR_W-1:0] addr_sh, rd_ptr, pend_addr, full_a;
  logic              rd_pend, drv, drain_vld;
  logic [ADDR_W-PW-1:0] pg_base;
  logic [PW-1:0]     start_off, wr_off, drain_off_d;
  logic [PW:0]       prog_cnt, drain_i, drain_n;
  logic [7:0]        in_byte;
  logic              out_st;

  assign in_byte  = {sh, si};
  assign full_a   = {addr_sh[ADDR_W-9:0], in_byte};
  assign out_st   = (state == S_RD) || (state == S_STAT) || (state == S_JID) || (state == S_RID);
  assign pb_raddr = start_off + drain_i[PW-1:0];

  always_comb begin
    case (state)
      S_RD:    ld = mem_q;
      S_STAT:  ld = status;
      S_JID:   case (id_idx)
                 2'd0:    ld = JEDEC_ID[23:16];
                 2'd1:    ld = JEDEC_ID[15:8];
                 default: ld = JEDEC_ID[7:0];
               endcase
      default: ld = DEV_ID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; pend_kind <= K_NONE; bit_cnt <= '0; obit <= '0;
      sh <= '0; osh <= '0; opc <= '0; mem_q <= '0; pend_data <= '0;
      addr_cnt <= '0; id_idx <= '0; addr_sh <= '0; rd_ptr <= '0; pend_addr <= '0;
      rd_pend <= 1'b0; drv <= 1'b0; drain_vld <= 1'b0; pg_base <= '0;
      start_off <= '0; wr_off <= '0; drain_off_d <= '0; prog_cnt <= '0;
      drain_i <= '0; drain_n <= '0; mem_rd_en <= 1'b0; mem_addr <= '0;
      so <= 1'b0; so_oe <= 1'b0; req_valid <= 1'b0; req_kind <= K_NONE;
      req_addr <= '0; req_data <= '0; pb_we <= 1'b0; pb_waddr <= '0; pb_wdata <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      req_valid <= 1'b0;
      pb_we     <= 1'b0;
      rd_pend   <= mem_rd_en;
      if (rd_pend) mem_q <= mem_rd_data;
      so_oe <= sel && !held && drv;

      if (state == S_DRAIN) begin
        // Replay the page buffer as per-byte program requests.
        drain_vld <= 1'b0;
        if (drain_i != drain_n) begin
          drain_off_d <= pb_raddr;
          drain_i     <= drain_i + ONE_C;
          drain_vld   <= 1'b1;
        end else if (!drain_vld) begin
          state <= S_IDLE;
        end
        if (drain_vld) begin
          req_valid <= 1'b1; req_kind <= K_PROG;
          req_addr  <= {pg_base, drain_off_d}; req_data <= pb_rdata;
        end
      end else if (cs_rise) begin
        drv <= 1'b0;
        bit_cnt <= '0;
        state <= S_IDLE;
        if (bit_cnt == 3'd0) begin
          if (state == S_ARMED) begin
            req_valid <= 1'b1; req_kind <= pend_kind;
            req_addr <= pend_addr; req_data <= pend_data;
          end else if (state == S_PROG && prog_cnt != '0) begin
            state <= S_DRAIN; drain_i <= '0; drain_n <= prog_cnt; drain_vld <= 1'b0;
          end else if (state == S_ADDR && opc == OP_RID && addr_cnt == 2'd0) begin
            req_valid <= 1'b1; req_kind <= K_RDPD; req_addr <= '0; req_data <= '0;
          end
        end
      end else if (cs_fall) begin
        state <= S_OPC; bit_cnt <= '0; obit <= '0; drv <= 1'b0;
        addr_cnt <= '0; id_idx <= '0; prog_cnt <= '0;
        pend_addr <= '0; pend_data <= '0; pend_kind <= K_NONE;
      end else begin
        if (sck_rise) begin
          sh <= in_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            case (state)
              S_OPC: begin
                opc <= in_byte;
                if (busy && in_byte != OP_RDSR) state <= S_SKIP;
                else begin
                  case (in_byte)
                    OP_READ, OP_FREAD, OP_PROG, OP_SE_A, OP_SE_B, OP_BE, OP_RID:
                      state <= S_ADDR;
                    OP_RDSR: state <= S_STAT;
                    OP_WRSR: state <= S_WSR;
                    OP_JID:  state <= S_JID;
                    OP_WREN: begin state <= S_ARMED; pend_kind <= K_WREN; end
                    OP_WRDI: begin state <= S_ARMED; pend_kind <= K_WRDI; end
                    OP_CE_A, OP_CE_B: begin state <= S_ARMED; pend_kind <= K_CHIP; end
                    OP_DPD:  begin state <= S_ARMED; pend_kind <= K_DPD; end
                    default: state <= S_SKIP;
                  endcase
                end
              end
              S_ADDR: begin
                addr_sh  <= full_a;
                addr_cnt <= addr_cnt + 2'd1;
                if (addr_cnt == 2'd2) begin
                  case (opc)
                    OP_READ, OP_FREAD: begin
                      state     <= (opc == OP_READ) ? S_RD : S_DUMMY;
                      rd_ptr    <= full_a;
                      mem_addr  <= full_a;
                      mem_rd_en <= 1'b1;
                    end
                    OP_PROG: begin
                      state     <= S_PROG;
                      pg_base   <= full_a[ADDR_W-1:PW];
                      start_off <= full_a[PW-1:0];
                      wr_off    <= full_a[PW-1:0];
                    end
                    OP_SE_A, OP_SE_B: begin
                      state <= S_ARMED; pend_kind <= K_SECT; pend_addr <= full_a & SEC_MASK;
                    end
                    OP_BE: begin
                      state <= S_ARMED; pend_kind <= K_BLK; pend_addr <= full_a & BLK_MASK;
                    end
                    default: state <= S_RID;
                  endcase
                end
              end
              S_DUMMY: state <= S_RD;
              S_WSR: begin
                state <= S_ARMED; pend_kind <= K_WRSR; pend_data <= in_byte;
              end
              S_PROG: begin
                pb_we    <= 1'b1;
                pb_waddr <= wr_off;
                pb_wdata <= in_byte;
                wr_off   <= wr_off + ONE_P;
                if (prog_cnt != PAGE_CNT) prog_cnt <= prog_cnt + ONE_C;
              end
              default: ;
            endcase
          end
        end
        if (sck_fall && out_st) begin
          obit <= obit + 3'd1;
          if (obit == 3'd0) begin
            drv <= 1'b1;
            so  <= ld[7];
            osh <= ld[6:0];
            if (state == S_RD) begin
              rd_ptr    <= rd_ptr + ONE_A;
              mem_addr  <= rd_ptr + ONE_A;
              mem_rd_en <= 1'b1;
            end
            if (state == S_JID) id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
          end else begin
            so  <= osh[6];
            osh <= {osh[5:0], 1'b0};
          end
        end
      end
    end
  end

  // R13
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_ADDR && $past(state) == S_OPC) |-> !$past(busy));

  // R10
  sect_align_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == K_SECT) |-> ((req_addr & ~SEC_MASK) == '0));

  // R10
  blk_align_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == K_BLK) |-> ((req_addr & ~BLK_MASK) == '0));

  // R12
  commit_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != K_PROG) |-> $past(cs_rise));

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    held |=> !so_oe);
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend #(
  parameter int          ADDR_W     = 18,
  parameter int          PAGE_BYTES = 256,
  parameter int          SEC_BITS   = 12,
  parameter int          BLK_BITS   = 16,
  parameter logic [23:0] JEDEC_ID   = 24'h5A3C12,
  parameter logic [7:0]  DEV_ID     = 8'h47
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic              busy,
  input  logic [7:0]        status_byte,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              req_valid,
  output logic [3:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic          sel, cs_fall, cs_rise, sck_rise, sck_fall, si_s, held;
  logic          pb_we;
  logic [PW-1:0] pb_waddr, pb_raddr;
  logic [7:0]    pb_wdata, pb_rdata;

  sfe_pin_front u_pins (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .hold_n_i(hold_n),
    .sel_o(sel), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise), .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall), .si_o(si_s), .held_o(held)
  );

  sfe_page_buf #(.DEPTH(PAGE_BYTES)) u_page (
    .clk(clk), .we(pb_we), .waddr(pb_waddr), .wdata(pb_wdata),
    .raddr(pb_raddr), .rdata(pb_rdata)
  );

  sfe_cmd_engine #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SEC_BITS(SEC_BITS),
    .BLK_BITS(BLK_BITS), .JEDEC_ID(JEDEC_ID), .DEV_ID(DEV_ID)
  ) u_eng (
    .clk(clk), .rst(rst), .sel(sel), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si(si_s), .held(held),
    .busy(busy), .status(status_byte),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .so(so), .so_oe(so_oe),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .pb_we(pb_we), .pb_waddr(pb_waddr), .pb_wdata(pb_wdata),
    .pb_raddr(pb_raddr), .pb_rdata(pb_rdata)
  );
endmodule

// File: tb/spi_flash_frontend_bench.sv
module spi_flash_frontend_bench;
  localparam int AW = 18;
  localparam int H  = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status_byte = 8'h00;
  logic so, so_oe, mem_rd_en, req_valid;
  logic [AW-1:0] mem_addr, req_addr;
  logic [7:0] mem_rd_data = 8'h00, req_data;
  logic [3:0] req_kind;

  int nchk = 0, nerr = 0, nreq = 0;
  logic [3:0]    q_kind [300];
  logic [AW-1:0] q_addr [300];
  logic [7:0]    q_data [300];

  always #2 clk = ~clk;

  spi_flash_frontend u_spi_flash_frontend (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .busy(busy), .status_byte(status_byte),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data)
  );

  function automatic logic [7:0] mpat(input logic [AW-1:0] a);
    return (a[7:0] + {a[17:16], a[13:8]}) ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mpat(mem_addr);

  always @(posedge clk) if (req_valid && nreq < 300) begin
    q_kind[nreq] = req_kind; q_addr[nreq] = req_addr; q_data[nreq] = req_data;
    nreq = nreq + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half(); repeat (H) @(negedge clk); endtask

  task automatic sel_on(input bit m3);
    @(negedge clk); sck = m3; half(); cs_n = 1'b0; half();
  endtask

  task automatic sel_off(input bit m3);
    if (!m3) begin sck = 1'b0; half(); end
    cs_n = 1'b1; half(); half();
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i]; half();
      rx[i] = so; sck = 1'b1; half();
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    xbyte(tx, d);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic t_reset();
    chk("R1 so_oe", so_oe, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 mem_rd_en", mem_rd_en, 0);
  endtask

  task automatic t_read(input string tag, input bit m3, input logic [7:0] op,
                        input logic [23:0] a, input int n);
    logic [7:0] d;
    logic [AW-1:0] p;
    int bad = 0;
    sel_on(m3); send(op); send_addr(a);
    if (op == 8'h0B) send(8'hFF);
    p = a[AW-1:0];
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, d);
      if (k == 0) chk({tag, " so_oe"}, so_oe, 1);
      if (d !== mpat(p)) begin
        bad++; $display("FAIL %s byte %0d actual=%0h expected=%0h", tag, k, d, mpat(p));
      end
      p = p + 1'b1;
    end
    nchk++; if (bad != 0) nerr++;
    sel_off(m3);
  endtask

  task automatic t_status();
    logic [7:0] d;
    sel_on(0); send(8'h05);
    status_byte = 8'h5C; xbyte(8'h00, d); chk("R6 first", d, 8'h5C);
    xbyte(8'h00, d); chk("R6 repeat", d, 8'h5C);
    status_byte = 8'h3A; xbyte(8'h00, d); chk("R6 resample", d, 8'h3A);
    sel_off(0);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    sel_on(0); send(8'h9F);
    xbyte(8'h00, d); chk("R7 jid0", d, 8'h5A);
    xbyte(8'h00, d); chk("R7 jid1", d, 8'h3C);
    xbyte(8'h00, d); chk("R7 jid2", d, 8'h12);
    xbyte(8'h00, d); chk("R7 jid wrap", d, 8'h5A);
    sel_off(0);
    nreq = 0;
    sel_on(1); send(8'hAB); send_addr(24'h000000);
    xbyte(8'h00, d); chk("R7 devid", d, 8'h47);
    xbyte(8'h00, d); chk("R7 devid repeat", d, 8'h47);
    sel_off(1);
    chk("R7 no req after id read", nreq, 0);
    sel_on(0); send(8'hAB); sel_off(0);
    chk("R7 release count", nreq, 1);
    chk("R7 release kind", q_kind[0], 9);
  endtask

  task automatic one_cmd(input string tag, input logic [7:0] op, input logic [3:0] kind);
    nreq = 0;
    sel_on(0); send(op); sel_off(0);
    chk({tag, " count"}, nreq, 1);
    chk({tag, " kind"}, q_kind[0], kind);
  endtask

  task automatic t_simple();
    one_cmd("R9 wren", 8'h06, 1);
    one_cmd("R9 wrdi", 8'h04, 2);
    one_cmd("R9 chip60", 8'h60, 5);
    one_cmd("R9 chipC7", 8'hC7, 5);
    one_cmd("R9 dpd", 8'hB9, 8);
    nreq = 0;
    sel_on(1); send(8'h01); send(8'h9C); sel_off(1);
    chk("R9 wrsr count", nreq, 1);
    chk("R9 wrsr kind", q_kind[0], 7);
    chk("R9 wrsr data", q_data[0], 8'h9C);
  endtask

  task automatic erase(input string tag, input logic [7:0] op, input logic [23:0] a,
                       input logic [3:0] kind, input logic [AW-1:0] ea);
    nreq = 0;
    sel_on(0); send(op); send_addr(a); sel_off(0);
    chk({tag, " count"}, nreq, 1);
    chk({tag, " kind"}, q_kind[0], kind);
    chk({tag, " addr"}, q_addr[0], ea);
  endtask

  task automatic t_erase();
    erase("R10 sect20", 8'h20, 24'hF12345, 3, 18'h12000);
    erase("R10 sectD7", 8'hD7, 24'h03FFFF, 3, 18'h3F000);
    erase("R10 blk", 8'hD8, 24'h03ABCD, 4, 18'h30000);
  endtask

  function automatic logic [7:0] pdat(input int k);
    return k[7:0] ^ 8'h3C ^ {7'd0, k[8]};
  endfunction

  task automatic t_program();
    int bad = 0;
    nreq = 0;
    sel_on(0); send(8'h02); send_addr(24'h0001FE);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    sel_off(0); repeat (40) @(negedge clk);
    chk("R11 short count", nreq, 4);
    chk("R11 a0", q_addr[0], 18'h001FE);
    chk("R11 a1", q_addr[1], 18'h001FF);
    chk("R11 in-page wrap addr", q_addr[2], 18'h00100);
    chk("R11 in-page wrap data", q_data[2], 8'h33);
    chk("R11 last", {q_kind[3], q_data[3]}, {4'd6, 8'h44});
    nreq = 0;
    sel_on(0); send(8'h02); send_addr(24'h000200);
    for (int k = 0; k < 258; k++) send(pdat(k));
    sel_off(0); repeat (300) @(negedge clk);
    chk("R11 full page count", nreq, 256);
    for (int j = 0; j < 256; j++) begin
      if (q_addr[j] !== 18'h00200 + 18'(j) ||
          q_data[j] !== pdat(j < 2 ? 256 + j : j) || q_kind[j] !== 4'd6) bad++;
    end
    chk("R11 overrun keeps last bytes", bad, 0);
  endtask

  task automatic t_abort();
    nreq = 0;
    sel_on(0);
    for (int i = 7; i >= 3; i--) begin
      sck = 1'b0; si = 8'h06 >> i; half(); sck = 1'b1; half();
    end
    sel_off(0);
    chk("R12 mid-byte abort", nreq, 0);
    sel_on(0); send(8'h20); send(8'h01); send(8'h00); sel_off(0);
    chk("R12 short address abort", nreq, 0);
    sel_on(0); send(8'h02); send_addr(24'h000000); sel_off(0);
    repeat (20) @(negedge clk);
    chk("R12 program without data", nreq, 0);
    one_cmd("R12 recovery", 8'h06, 1);
  endtask

  task automatic t_busy();
    logic [7:0] d;
    busy = 1'b1; nreq = 0;
    sel_on(0); send(8'h06); sel_off(0);
    chk("R13 wren blocked", nreq, 0);
    sel_on(0); send(8'h03); send_addr(24'h000010); xbyte(8'h00, d);
    chk("R13 read blocked", so_oe, 0);
    sel_off(0);
    status_byte = 8'h01;
    sel_on(0); send(8'h05); xbyte(8'h00, d);
    chk("R13 status allowed", d, 8'h01);
    sel_off(0);
    busy = 1'b0;
  endtask

  task automatic t_hold();
    logic [7:0] d;
    sel_on(0); send(8'h03); send_addr(24'h000040);
    xbyte(8'h00, d); chk("R8 byte before hold", d, mpat(18'h40));
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = 1'b0; half();
      if (i == 4) begin
        hold_n = 1'b0; half();
        chk("R8 so hi-z in hold", so_oe, 0);
        sck = 1'b1; half(); sck = 1'b0; half();
        sck = 1'b1; half(); sck = 1'b0; half();
        hold_n = 1'b1; half();
        chk("R8 so back after hold", so_oe, 1);
      end
      d[i] = so; sck = 1'b1; half();
    end
    chk("R8 byte across hold", d, mpat(18'h41));
    xbyte(8'h00, d); chk("R8 byte after hold", d, mpat(18'h42));
    sel_off(0);
    sel_on(0); send(8'h03); send_addr(24'h000000);
    sck = 1'b0; half(); hold_n = 1'b0; half(); half();
    cs_n = 1'b1; half(); hold_n = 1'b1; half();
    chk("R8 deselect in hold", so_oe, 0);
    one_cmd("R8 standby after hold", 8'h04, 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read("R2 mode0 read", 0, 8'h03, 24'hFC0010, 3);
    t_read("R3 mode3 read", 1, 8'h03, 24'h012345, 3);
    t_read("R4 fast read", 0, 8'h0B, 24'h012345, 2);
    t_read("R5 wrap", 0, 8'h03, 24'h03FFFE, 4);
    t_status();
    t_ids();
    t_simple();
    t_erase();
    t_program();
    t_abort();
    t_busy();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule